// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter with Compare Flags

This block is an 8-bit timer/counter peripheral for a small 8-bit processor. A single bus write port reaches four byte registers: a control byte, the live count and two compare values (A and B). The control byte selects how often the count advances, either every system clock, every 8th or every 64th clock, or not at all. It also selects between a free-running mode and a mode where the count clears after it reaches compare A.

Three sticky status flags sit in the upper bits of the control byte. They record a rollover from 255 to 0, a match against compare A and a match against compare B. The overflow and compare-A flags each drive a level interrupt request when their enable bit is set. An acknowledge pulse from the interrupt controller clears the corresponding flag. The compare-B flag has no request line and only software can clear it. A typical use is a 25% duty-cycle waveform: compare A at 191 turns an output on, and the overflow turns it off again.

Top module: `tmr8_unit`

## Requirements
- R1: After reset every register reads 0 and both request lines are low.
- R2: Register addresses: 0 control byte, 1 count, 2 compare A, 3 compare B. Reads are combinational from the addressed register. A write takes effect at the clock edge where bus_we is high, and a count write overrides any advance in that cycle.
- R3: Control bits [1:0] select the advance rate: 00 stopped (the count holds), 01 every clock, 10 every 8th clock, 11 every 64th clock. After a write that starts the timer from 00, the first advance comes a full rate period after that write's edge.
- R4: With control bit 2 at 0, an advance from 255 gives 0.
- R5: With control bit 2 at 1, an advance while the count equals compare A gives 0. Otherwise the count increments.
- R6: Control bit 5 (overflow flag) is set by an advance from 255.
- R7: Control bit 6 (compare-A flag) is set by an advance while the count equals compare A. Control bit 7 (compare-B flag) is set by an advance while the count equals compare B.
- R8: Writing 0 to a flag bit at address 0 clears that flag, and writing 1 leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R9: ovf_irq equals the overflow flag AND bit 3; cmpa_irq equals the compare-A flag AND bit 4. An ovf_ack pulse clears the overflow flag and a cmpa_ack pulse clears the compare-A flag. No acknowledge affects the compare-B flag.
- R10: In free-running mode with rate 11 and compare A at 191, compare-A events repeat every 16384 clocks, and each overflow follows its compare-A event by 4096 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| ovf_ack | input | 1 | Overflow request acknowledge |
| cmpa_ack | input | 1 | Compare-A request acknowledge |
| ovf_irq | output | 1 | Overflow interrupt request (level) |
| cmpa_irq | output | 1 | Compare-A interrupt request (level) |

## Verification
A hardware flag set and a software clear of the same flag can land on one clock edge. The bench provokes this by starting the timer at count 255 and writing 0 to the overflow bit on the very edge where the count rolls to 0, then reading the control byte, which must still show the flag. Acknowledges that arrive while a flag is being set are judged the same way by the cycle-accurate reference model, which is compared against the read data and both request lines on every clock.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_CNT  = 2'd1,
        ADDR_CMPA = 2'd2,
        ADDR_CMPB = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        PS_STOP  = 2'b00,
        PS_DIV1  = 2'b01,
        PS_MID   = 2'b10,
        PS_HIGH  = 2'b11
    } ps_code_e;

    // Control byte, bit 7 first; software decodes this layout.
    typedef struct packed {
        logic       flag_b;
        logic       flag_a;
        logic       flag_ovf;
        logic       en_a;
        logic       en_ovf;
        logic       ctc;
        logic [1:0] ps;
    } ctrl_t;

endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
    import tmr8_pkg::*;
#(
    parameter int DIV_MID  = 8,
    parameter int DIV_HIGH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ps_sel,
    output logic       tick
);
    localparam int DIV_W = (DIV_HIGH > 1) ? $clog2(DIV_HIGH) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [DIV_W-1:0] lim_m1;
    logic             run;

    always_comb begin
        run = (ps_code_e'(ps_sel) != PS_STOP);
        unique case (ps_code_e'(ps_sel))
            PS_MID:  lim_m1 = DIV_W'(DIV_MID - 1);
            PS_HIGH: lim_m1 = DIV_W'(DIV_HIGH - 1);
            default: lim_m1 = '0;
        endcase
        tick = run && (st_q.div >= lim_m1);
        st_d = st_q;
        if (!run || tick) begin
            st_d.div = '0;
        end else begin
            st_d.div = st_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    start_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ps_sel) == PS_STOP && ps_sel != PS_STOP && ps_sel != PS_DIV1) |-> !tick);

endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter
    import tmr8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctc,
    input  logic [CNT_W-1:0] ocra,
    input  logic [CNT_W-1:0] ocrb,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_ev,
    output logic             cmpa_ev,
    output logic             cmpb_ev
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        ovf_ev  = tick && (st_q.cnt == CNT_MAX);
        cmpa_ev = tick && (st_q.cnt == ocra);
        cmpb_ev = tick && (st_q.cnt == ocrb);
        st_d    = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            if (ctc && (st_q.cnt == ocra)) st_d.cnt = '0;
            else                           st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ctc && !load && st_q.cnt == CNT_MAX) |=> (st_q.cnt == '0));

    // R5
    ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctc && !load && st_q.cnt == ocra) |=> (st_q.cnt == '0));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(st_q.cnt));

endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags
    import tmr8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [7:0] wdata,
    input  logic       ovf_ev,
    input  logic       cmpa_ev,
    input  logic       cmpb_ev,
    input  logic       ovf_ack,
    input  logic       cmpa_ack,
    output logic [7:0] ctrl_byte,
    output logic       ovf_irq,
    output logic       cmpa_irq
);
    ctrl_t ctrl_d, ctrl_q;
    ctrl_t wr;

    always_comb begin
        wr     = ctrl_t'(wdata);
        ctrl_d = ctrl_q;
        if (ctrl_we) begin
            ctrl_d.en_a   = wr.en_a;
            ctrl_d.en_ovf = wr.en_ovf;
            ctrl_d.ctc    = wr.ctc;
            ctrl_d.ps     = wr.ps;
            if (!wr.flag_b)   ctrl_d.flag_b   = 1'b0;
            if (!wr.flag_a)   ctrl_d.flag_a   = 1'b0;
            if (!wr.flag_ovf) ctrl_d.flag_ovf = 1'b0;
        end
        if (ovf_ack)  ctrl_d.flag_ovf = 1'b0;
        if (cmpa_ack) ctrl_d.flag_a   = 1'b0;
        // hardware events win over every clear
        if (ovf_ev)   ctrl_d.flag_ovf = 1'b1;
        if (cmpa_ev)  ctrl_d.flag_a   = 1'b1;
        if (cmpb_ev)  ctrl_d.flag_b   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_byte = ctrl_q;
    assign ovf_irq   = ctrl_q.flag_ovf & ctrl_q.en_ovf;
    assign cmpa_irq  = ctrl_q.flag_a & ctrl_q.en_a;

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_ev |=> ctrl_q.flag_ovf);

    // R8
    keep_on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wdata[7] && ctrl_q.flag_b) |=> ctrl_q.flag_b);

    // R9
    cmpb_sw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_q.flag_b) |-> $past(ctrl_we && !wdata[7]));

    // R9
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_ack && !ovf_ev) |=> !ovf_irq);

endmodule

// File: rtl/tmr8_unit.sv
module tmr8_unit
    import tmr8_pkg::*;
#(
    parameter int DIV_MID  = 8,
    parameter int DIV_HIGH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ovf_ack,
    input  logic       cmpa_ack,
    output logic       ovf_irq,
    output logic       cmpa_irq
);
    typedef struct packed {
        logic [CNT_W-1:0] ocra;
        logic [CNT_W-1:0] ocrb;
    } cmp_regs_t;

    cmp_regs_t        regs_d, regs_q;
    reg_addr_e        addr_sel;
    logic             wr_ctrl, wr_cnt;
    logic             tick;
    logic             ovf_ev, cmpa_ev, cmpb_ev;
    logic [7:0]       ctrl_byte;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        addr_sel = reg_addr_e'(bus_addr);
        wr_ctrl  = bus_we && (addr_sel == ADDR_CTRL);
        wr_cnt   = bus_we && (addr_sel == ADDR_CNT);
        regs_d   = regs_q;
        if (bus_we && addr_sel == ADDR_CMPA) regs_d.ocra = bus_wdata;
        if (bus_we && addr_sel == ADDR_CMPB) regs_d.ocrb = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    tmr8_prescaler #(
        .DIV_MID  (DIV_MID),
        .DIV_HIGH (DIV_HIGH)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .ps_sel (ctrl_byte[1:0]),
        .tick   (tick)
    );

    tmr8_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ctc      (ctrl_byte[2]),
        .ocra     (regs_q.ocra),
        .ocrb     (regs_q.ocrb),
        .load     (wr_cnt),
        .load_val (bus_wdata),
        .cnt      (cnt),
        .ovf_ev   (ovf_ev),
        .cmpa_ev  (cmpa_ev),
        .cmpb_ev  (cmpb_ev)
    );

    tmr8_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (wr_ctrl),
        .wdata     (bus_wdata),
        .ovf_ev    (ovf_ev),
        .cmpa_ev   (cmpa_ev),
        .cmpb_ev   (cmpb_ev),
        .ovf_ack   (ovf_ack),
        .cmpa_ack  (cmpa_ack),
        .ctrl_byte (ctrl_byte),
        .ovf_irq   (ovf_irq),
        .cmpa_irq  (cmpa_irq)
    );

    always_comb begin
        unique case (addr_sel)
            ADDR_CTRL: bus_rdata = ctrl_byte;
            ADDR_CNT:  bus_rdata = cnt;
            ADDR_CMPA: bus_rdata = regs_q.ocra;
            ADDR_CMPB: bus_rdata = regs_q.ocrb;
        endcase
    end

    // R2
    cmpa_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd2) |=> (regs_q.ocra == $past(bus_wdata)));

    // R2
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd1) |=> (cnt == $past(bus_wdata)));

endmodule

// File: tb/tmr8_unit_bench.sv
module tmr8_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic       ovf_ack = 1'b0;
    logic       cmpa_ack = 1'b0;
    logic [7:0] bus_rdata;
    logic       ovf_irq, cmpa_irq;

    always #5 clk = ~clk;

    tmr8_unit u_tmr8_unit (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_ack(ovf_ack),
        .cmpa_ack(cmpa_ack), .ovf_irq(ovf_irq), .cmpa_irq(cmpa_irq)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // behavioural reference model
    int m_cnt, m_ocra, m_ocrb, m_div, m_ps, m_lim;
    bit m_fb, m_fa, m_fo, m_ea, m_eo, m_tm, m_tk, m_xo, m_xa, m_xb;

    always @(posedge clk) cyc++;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_ocra = 0; m_ocrb = 0; m_div = 0; m_ps = 0;
            m_fb = 0; m_fa = 0; m_fo = 0; m_ea = 0; m_eo = 0; m_tm = 0;
        end else begin
            m_lim = (m_ps == 1) ? 1 : ((m_ps == 2) ? 8 : 64);
            m_tk = 0;
            if (m_ps == 0) m_div = 0;
            else if (m_div >= m_lim - 1) begin m_tk = 1; m_div = 0; end
            else m_div++;
            m_xo = m_tk && (m_cnt == 255);
            m_xa = m_tk && (m_cnt == m_ocra);
            m_xb = m_tk && (m_cnt == m_ocrb);
            if (bus_we && bus_addr == 1) m_cnt = bus_wdata;
            else if (m_tk) m_cnt = (m_tm && m_cnt == m_ocra) ? 0 : (m_cnt + 1) % 256;
            if (bus_we && bus_addr == 2) m_ocra = bus_wdata;
            if (bus_we && bus_addr == 3) m_ocrb = bus_wdata;
            if (bus_we && bus_addr == 0) begin
                if (!bus_wdata[7]) m_fb = 0;
                if (!bus_wdata[6]) m_fa = 0;
                if (!bus_wdata[5]) m_fo = 0;
                m_ea = bus_wdata[4]; m_eo = bus_wdata[3];
                m_tm = bus_wdata[2]; m_ps = bus_wdata[1:0];
            end
            if (ovf_ack)  m_fo = 0;
            if (cmpa_ack) m_fa = 0;
            if (m_xo) m_fo = 1;
            if (m_xa) m_fa = 1;
            if (m_xb) m_fb = 1;
        end
    end

    function automatic int model_rd(input logic [1:0] a);
        case (a)
            2'd0: return {m_fb, m_fa, m_fo, m_ea, m_eo, m_tm, m_ps[1:0]};
            2'd1: return m_cnt;
            2'd2: return m_ocra;
            default: return m_ocrb;
        endcase
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        #3;
        if (rst_n && !done) begin
            chk("R2 read data vs model", bus_rdata, model_rd(bus_addr));
            chk("R9 ovf_irq vs model", ovf_irq, int'(m_fo && m_eo));
            chk("R9 cmpa_irq vs model", cmpa_irq, int'(m_fa && m_ea));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_irq(input bit on_ovf, output int t);
        int n = 0;
        while (((on_ovf ? ovf_irq : cmpa_irq) == 1'b0) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        t = cyc;
    endtask

    task automatic pulse_ack(input bit on_ovf, input bit on_a);
        ovf_ack = on_ovf; cmpa_ack = on_a;
        @(negedge clk);
        ovf_ack = 1'b0; cmpa_ack = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int v, t_a1, t_o, t_a2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 register after reset", v, 0);
        end
        chk("R1 ovf_irq after reset", ovf_irq, 0);
        chk("R1 cmpa_irq after reset", cmpa_irq, 0);

        // R2 register writes
        wr(2'd2, 8'd10);
        wr(2'd3, 8'd5);
        wr(2'd1, 8'd250);
        rd(2'd2, v); chk("R2 compare A", v, 10);
        rd(2'd3, v); chk("R2 compare B", v, 5);
        rd(2'd1, v); chk("R2 count", v, 250);
        repeat (5) @(negedge clk);
        rd(2'd1, v); chk("R3 stopped holds count", v, 250);

        // R3 start, R4 wrap, R6 overflow flag
        wr(2'd0, 8'h01);
        rd(2'd1, v); chk("R3 no advance on start edge", v, 250);
        @(negedge clk);
        rd(2'd1, v); chk("R3 first advance", v, 251);
        repeat (5) @(negedge clk);
        rd(2'd1, v); chk("R4 wrap to zero", v, 0);
        rd(2'd0, v); chk("R6 overflow flag set", v, 8'h21);
        chk("R9 no request while disabled", ovf_irq, 0);

        // R8 write one keeps, write zero clears
        wr(2'd0, 8'h21);
        rd(2'd0, v); chk("R8 write one keeps flag", v & 8'h20, 8'h20);
        wr(2'd0, 8'h01);
        rd(2'd0, v); chk("R8 write zero clears flag", v & 8'h20, 0);

        // R7 compare flags, R9 acks
        repeat (12) @(negedge clk);
        rd(2'd0, v); chk("R7 compare A and B flags", v & 8'hE0, 8'hC0);
        pulse_ack(1'b1, 1'b1);
        rd(2'd0, v); chk("R9 ack clears A but not B", v & 8'hE0, 8'h80);

        // R9 overflow request and acknowledge
        wr(2'd0, 8'h19);
        wait_irq(1'b1, v);
        chk("R9 overflow request raised", ovf_irq, 1);
        rd(2'd0, v); chk("R9 overflow flag behind request", v & 8'h20, 8'h20);
        pulse_ack(1'b1, 1'b0);
        chk("R9 request drops after ack", ovf_irq, 0);

        // R8 hardware set beats software clear in the same cycle
        wr(2'd0, 8'h00);
        wr(2'd1, 8'd255);
        wr(2'd0, 8'h01);
        wr(2'd0, 8'h01);
        rd(2'd0, v); chk("R8 set wins over clear", v & 8'h20, 8'h20);
        rd(2'd1, v); chk("R4 rolled over", v, 0);

        // R5 clear-on-compare mode
        wr(2'd0, 8'h00);
        wr(2'd2, 8'd3);
        wr(2'd1, 8'd0);
        wr(2'd0, 8'h05);
        repeat (3) @(negedge clk);
        rd(2'd1, v); chk("R5 reaches compare A", v, 3);
        @(negedge clk);
        rd(2'd1, v); chk("R5 clears after compare A", v, 0);
        rd(2'd0, v); chk("R5 only compare A flag", v & 8'hE0, 8'h40);

        // R10 25% waveform timing
        wr(2'd0, 8'h00);
        wr(2'd2, 8'd191);
        wr(2'd1, 8'd0);
        wr(2'd0, 8'h1B);
        wait_irq(1'b0, t_a1);
        pulse_ack(1'b0, 1'b1);
        wait_irq(1'b1, t_o);
        pulse_ack(1'b1, 1'b0);
        wait_irq(1'b0, t_a2);
        pulse_ack(1'b0, 1'b1);
        chk("R10 compare-to-overflow clocks", t_o - t_a1, 4096);
        chk("R10 waveform period clocks", t_a2 - t_a1, 16384);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule